// File: doc/BRIEF.md
# Predicated Contiguous Vector Store Sequencer

This block carries out one masked store of 64-bit lanes from a vector register into memory. A single-cycle start command hands it a 32-bit instruction word, the full vector register value, the governing byte-granular predicate, and two candidate base values: the general register selected by the instruction and the stack pointer. The block decodes the word, forms the first address from a signed immediate scaled by the whole vector length, and makes the stack-pointer alignment check. It then steps through the lanes from lane 0 upward, and for each lane whose predicate is set it issues one 8-byte write on a valid/ready port.

Every write carries a non-temporal hint. It also carries a tag-check flag that is set only when the base came from a general register. The operation ends with a one-cycle done pulse or with a one-cycle fault pulse and a fault code. The register files, the tag checking and the memory are outside the block.

Top module: `vst_seq`

## Requirements
- R1: The word is legal only when bits 31:20 equal 12'hE59 and bits 15:13 equal 3'b111. An illegal word ends the operation with a fault pulse, fault_code 1, and no write.
- R2: The first address is base + sext(bits 19:16) × (VLEN/8), computed modulo 2^64. The immediate is a 4-bit two's-complement value from -8 to 7.
- R3: Lane e is active exactly when predicate bit 8·e is set. The other seven bits of each 8-bit predicate group have no effect.
- R4: Lanes are visited in ascending order. Lane e is written at first address + 8·e with data vreg[64·e+63:64·e].
- R5: An inactive lane produces no write, so an operation issues exactly as many writes as it has active lanes.
- R6: Base register number 31 (bits 9:5) selects sp_val and drives wr_tagchk low. Any other number selects xbase and drives wr_tagchk high.
- R7: With base number 31, at least one active lane, and sp_val[3:0] not zero, the operation faults with fault_code 2 and makes no write.
- R8: With base number 31 and no active lane, the alignment check of R7 is made only when SP_CHECK_EMPTY is 1 (the default). An operation with no active lane that does not fault ends with done and no write.
- R9: wr_nontemporal is high on every write beat.
- R10: While wr_valid is high and wr_ready is low, wr_valid, wr_addr and wr_data hold their values into the next cycle.
- R11: done and fault are single-cycle pulses that never occur together. Exactly one of them ends each accepted command. A start that arrives while busy is high has no effect.
- R12: After reset, busy, wr_valid, done and fault are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, accepted only when idle |
| insn | input | 32 | Instruction word |
| vreg | input | VLEN | Source vector register value |
| pred | input | VLEN/8 | Governing predicate, one bit per vector byte |
| xbase | input | 64 | General-register base value |
| sp_val | input | 64 | Stack-pointer value |
| busy | output | 1 | High from command acceptance until the end pulse |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Memory accepts the beat |
| wr_addr | output | 64 | Byte address of the beat |
| wr_data | output | 64 | Lane data of the beat |
| wr_nontemporal | output | 1 | Non-temporal hint |
| wr_tagchk | output | 1 | Tag check requested for the beat |
| done | output | 1 | Successful completion pulse |
| fault | output | 1 | Fault pulse |
| fault_code | output | 2 | 1 = illegal word, 2 = stack misalignment; valid with fault |

## Verification
The assertions check four things on every cycle: a stalled beat holds steady, the hint is present on each beat, the end pulses are single and mutually exclusive, and a write appears only while busy and, within one operation, at an 8-byte step from the previous write. The scenarios in the bench cover the behaviour that needs a reference model:
- immediate scaling and 64-bit wraparound;
- which predicate bits count;
- base selection and the tag flag;
- the alignment rules with and without active lanes;
- rejection of illegal words;
- a second start arriving mid-operation.

// File: rtl/vst_pkg.sv
package vst_pkg;

    localparam logic [11:0] OPC_HI      = 12'hE59;
    localparam logic [2:0]  OPC_MID     = 3'b111;
    localparam logic [4:0]  SP_SEL      = 5'd31;
    localparam int unsigned LANE_BITS   = 64;
    localparam int unsigned LANE_BYTES  = LANE_BITS / 8;
    localparam int unsigned SP_ALIGN_LSB = 4;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_DECODE = 2'd1,
        FLT_ALIGN  = 2'd2
    } flt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_WALK = 2'd2
    } st_e;

    typedef struct packed {
        logic       legal;
        logic [3:0] imm;
        logic [2:0] pg;
        logic [4:0] rn;
        logic [4:0] zt;
    } cmd_t;

    function automatic cmd_t decode_word(input logic [31:0] w);
        cmd_t c;
        c.legal = (w[31:20] == OPC_HI) && (w[15:13] == OPC_MID);
        c.imm   = w[19:16];
        c.pg    = w[12:10];
        c.rn    = w[9:5];
        c.zt    = w[4:0];
        return c;
    endfunction

    function automatic logic [63:0] scale_imm(input logic [3:0] imm,
                                              input logic [63:0] unit);
        logic [63:0] ext;
        ext = {{60{imm[3]}}, imm};
        return ext * unit;
    endfunction

endpackage

// File: rtl/vst_decode.sv
module vst_decode
    import vst_pkg::*;
(
    input  logic [31:0] word,
    output cmd_t        cmd
);
    always_comb begin
        cmd = decode_word(word);
    end
endmodule

// File: rtl/vst_pred_map.sv
module vst_pred_map #(
    parameter int VLEN = 256
) (
    input  logic [VLEN/8-1:0]  pred,
    output logic [VLEN/64-1:0] lane_act,
    output logic               any_act
);
    localparam int NLANE = VLEN / 64;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lane_act[g] = pred[g*8];
    end

    assign any_act = |lane_act;
endmodule

// File: rtl/vst_agen.sv
module vst_agen
    import vst_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic [4:0]  rn,
    input  logic [3:0]  imm,
    input  logic [63:0] xbase,
    input  logic [63:0] sp_val,
    output logic        use_sp,
    output logic        sp_misaligned,
    output logic [63:0] first_addr
);
    localparam logic [63:0] STRIDE = 64'(VLEN / 8);

    logic [63:0] base;

    always_comb begin
        use_sp        = (rn == SP_SEL);
        base          = use_sp ? sp_val : xbase;
        sp_misaligned = |sp_val[SP_ALIGN_LSB-1:0];
        first_addr    = base + scale_imm(imm, STRIDE);
    end
endmodule

// File: rtl/vst_seq.sv
module vst_seq
    import vst_pkg::*;
#(
    parameter int VLEN           = 256,
    parameter bit SP_CHECK_EMPTY = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [31:0]       insn,
    input  logic [VLEN-1:0]   vreg,
    input  logic [VLEN/8-1:0] pred,
    input  logic [63:0]       xbase,
    input  logic [63:0]       sp_val,
    output logic              busy,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [63:0]       wr_addr,
    output logic [63:0]       wr_data,
    output logic              wr_nontemporal,
    output logic              wr_tagchk,
    output logic              done,
    output logic              fault,
    output logic [1:0]        fault_code
);
    localparam int NLANE = VLEN / 64;
    localparam int PW    = VLEN / 8;
    localparam int IW    = (NLANE > 1) ? $clog2(NLANE) : 1;
    localparam logic [IW-1:0] LAST = IW'(NLANE - 1);

    st_e              state;
    logic [31:0]      insn_q;
    logic [VLEN-1:0]  vreg_q;
    logic [PW-1:0]    pred_q;
    logic [63:0]      xbase_q;
    logic [63:0]      sp_q;
    logic [IW-1:0]    idx;
    logic [63:0]      cur_addr;
    flt_e             code_q;

    cmd_t             cmd;
    logic [NLANE-1:0] lane_act;
    logic             any_act;
    logic             use_sp;
    logic             sp_misaligned;
    logic [63:0]      first_addr;
    logic [63:0]      lane_data [NLANE];
    logic             cur_act;
    logic             step;

    vst_decode u_dec (
        .word (insn_q),
        .cmd  (cmd)
    );

    vst_pred_map #(.VLEN(VLEN)) u_pmap (
        .pred     (pred_q),
        .lane_act (lane_act),
        .any_act  (any_act)
    );

    vst_agen #(.VLEN(VLEN)) u_agen (
        .rn            (cmd.rn),
        .imm           (cmd.imm),
        .xbase         (xbase_q),
        .sp_val        (sp_q),
        .use_sp        (use_sp),
        .sp_misaligned (sp_misaligned),
        .first_addr    (first_addr)
    );

    for (genvar g = 0; g < NLANE; g++) begin : g_data
        assign lane_data[g] = vreg_q[g*LANE_BITS +: LANE_BITS];
    end

    assign cur_act = lane_act[idx];
    assign step    = (state == ST_WALK) && (!cur_act || wr_ready);

    assign busy           = (state != ST_IDLE);
    assign wr_valid       = (state == ST_WALK) && cur_act;
    assign wr_addr        = cur_addr;
    assign wr_data        = lane_data[idx];
    assign wr_nontemporal = 1'b1;
    assign wr_tagchk      = !use_sp;
    assign fault_code     = code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            insn_q   <= '0;
            vreg_q   <= '0;
            pred_q   <= '0;
            xbase_q  <= '0;
            sp_q     <= '0;
            idx      <= '0;
            cur_addr <= '0;
            done     <= 1'b0;
            fault    <= 1'b0;
            code_q   <= FLT_NONE;
        end else begin
            done   <= 1'b0;
            fault  <= 1'b0;
            code_q <= FLT_NONE;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        insn_q  <= insn;
                        vreg_q  <= vreg;
                        pred_q  <= pred;
                        xbase_q <= xbase;
                        sp_q    <= sp_val;
                        state   <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (!cmd.legal) begin
                        fault  <= 1'b1;
                        code_q <= FLT_DECODE;
                        state  <= ST_IDLE;
                    end else if (use_sp && sp_misaligned &&
                                 (any_act || SP_CHECK_EMPTY)) begin
                        fault  <= 1'b1;
                        code_q <= FLT_ALIGN;
                        state  <= ST_IDLE;
                    end else if (!any_act) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        idx      <= '0;
                        cur_addr <= first_addr;
                        state    <= ST_WALK;
                    end
                end
                ST_WALK: begin
                    if (step) begin
                        cur_addr <= cur_addr + 64'(LANE_BYTES);
                        if (idx == LAST) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vst_seq_chk.sv
module vst_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [63:0] wr_addr,
    input logic [63:0] wr_data,
    input logic        wr_nontemporal,
    input logic        done,
    input logic        fault
);
    logic        have_prev;
    logic [63:0] prev_addr;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            have_prev <= 1'b0;
            prev_addr <= '0;
        end else if (wr_valid && wr_ready) begin
            have_prev <= 1'b1;
            prev_addr <= wr_addr;
        end
    end

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R9
    nt_hint_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> wr_nontemporal);

    // R11
    end_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, fault}));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12
    write_busy_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> busy);

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && have_prev) |->
            ((wr_addr != prev_addr) && ((wr_addr - prev_addr) & 64'h7) == 64'h0));
endmodule

bind vst_seq vst_seq_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .busy           (busy),
    .wr_valid       (wr_valid),
    .wr_ready       (wr_ready),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .wr_nontemporal (wr_nontemporal),
    .done           (done),
    .fault          (fault)
);

// File: tb/vst_seq_bench.sv
module vst_seq_bench;
    localparam int VLEN  = 256;
    localparam int NLANE = VLEN / 64;
    localparam int PW    = VLEN / 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              start;
    logic [31:0]       insn;
    logic [VLEN-1:0]   vreg;
    logic [PW-1:0]     pred;
    logic [63:0]       xbase, sp_val;
    logic              busy, wr_valid, wr_ready;
    logic [63:0]       wr_addr, wr_data;
    logic              wr_nontemporal, wr_tagchk, done, fault;
    logic [1:0]        fault_code;

    always #5 clk = ~clk;

    vst_seq #(.VLEN(VLEN), .SP_CHECK_EMPTY(1'b1)) u_vst_seq (
        .clk(clk), .rst(rst), .start(start), .insn(insn), .vreg(vreg),
        .pred(pred), .xbase(xbase), .sp_val(sp_val), .busy(busy),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_nontemporal(wr_nontemporal),
        .wr_tagchk(wr_tagchk), .done(done), .fault(fault),
        .fault_code(fault_code)
    );

    // kind: 0 legal, 1 bad bits 31:20, 2 bad bits 15:13
    typedef struct packed {
        logic [1:0]  kind;
        logic [3:0]  imm;
        logic [4:0]  rn;
        logic [31:0] pr;
        logic [63:0] base;
    } tv_t;

    localparam int NTV = 10;
    localparam tv_t TV [NTV] = '{
        '{2'd0, 4'h0, 5'd3,  32'h01010101, 64'h0000_0000_8000_0000},
        '{2'd0, 4'h8, 5'd5,  32'h00000101, 64'h0000_0000_0001_0000},
        '{2'd0, 4'h7, 5'd31, 32'h01000001, 64'h0000_0000_0000_1000},
        '{2'd0, 4'h0, 5'd31, 32'h00010000, 64'h0000_0000_0000_1008},
        '{2'd0, 4'h2, 5'd31, 32'hFEFEFEFE, 64'h0000_0000_0000_2004},
        '{2'd0, 4'h1, 5'd2,  32'hFEFEFEFE, 64'h0000_0000_0000_4000},
        '{2'd1, 4'h0, 5'd4,  32'hFFFFFFFF, 64'h0000_0000_0000_5000},
        '{2'd0, 4'h1, 5'd1,  32'hFFFFFFFF, 64'hFFFF_FFFF_FFFF_FFF0},
        '{2'd2, 4'h3, 5'd6,  32'h01010101, 64'h0000_0000_0000_6000},
        '{2'd0, 4'hF, 5'd31, 32'h00000100, 64'h0000_0000_0000_3000}
    };

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // monitor
    int          n_wr, n_done, n_fault;
    logic [1:0]  last_code;
    logic [63:0] mon_addr [8];
    logic [63:0] mon_data [8];
    logic        mon_tag  [8];
    logic        mon_nt   [8];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst) begin
            if (wr_valid && wr_ready) begin
                if (n_wr < 8) begin
                    mon_addr[n_wr] <= wr_addr;
                    mon_data[n_wr] <= wr_data;
                    mon_tag[n_wr]  <= wr_tagchk;
                    mon_nt[n_wr]   <= wr_nontemporal;
                end
                n_wr <= n_wr + 1;
            end
            if (done) n_done <= n_done + 1;
            if (fault) begin
                n_fault   <= n_fault + 1;
                last_code <= fault_code;
            end
        end
    end

    logic [15:0] lfsr = 16'hACE1;
    always @(negedge clk) begin
        lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        wr_ready <= lfsr[0] | lfsr[3];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_insn(input logic [1:0] kind,
                                            input logic [3:0] imm,
                                            input logic [4:0] rn, input int t);
        logic [11:0] hi;
        logic [2:0]  mid;
        hi  = (kind == 2'd1) ? 12'hE58 : 12'hE59;
        mid = (kind == 2'd2) ? 3'b110 : 3'b111;
        return {hi, imm, mid, 3'(t), rn, 5'(t + 7)};
    endfunction

    function automatic logic [63:0] lane_val(input int t, input int e);
        return 64'hA5C3_0000_0000_0000 | (64'(t) << 16) | (64'(e) << 4) | 64'h9;
    endfunction

    task automatic run_op(input int t, input bit inject);
        tv_t         v;
        logic [63:0] xb, spv, bsel, first, off;
        logic [NLANE-1:0] act;
        logic        any, legal, use_sp;
        logic [1:0]  ecode;
        int          k, nexp;
        v      = TV[t];
        use_sp = (v.rn == 5'd31);
        xb     = use_sp ? 64'h0000_DEAD_0000_0000 : v.base;
        spv    = use_sp ? v.base : 64'h0000_BEEF_0000_0008;
        bsel   = use_sp ? spv : xb;
        off    = {{60{v.imm[3]}}, v.imm} * 64'(VLEN / 8);
        first  = bsel + off;
        for (int e = 0; e < NLANE; e++) act[e] = v.pr[e*8];
        any    = |act;
        legal  = (v.kind == 2'd0);
        if (!legal) ecode = 2'd1;
        else if (use_sp && spv[3:0] != 4'h0) ecode = 2'd2;
        else ecode = 2'd0;

        @(negedge clk);
        n_wr = 0; n_done = 0; n_fault = 0; last_code = 2'd0;
        insn   = mk_insn(v.kind, v.imm, v.rn, t);
        for (int e = 0; e < NLANE; e++) vreg[e*64 +: 64] = lane_val(t, e);
        pred   = v.pr;
        xbase  = xb;
        sp_val = spv;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        if (inject) begin
            @(negedge clk);
            insn  = 32'h0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        k = 0;
        while (n_done == 0 && n_fault == 0 && k < 300) begin
            @(negedge clk);
            k++;
        end
        repeat (4) @(negedge clk);

        nexp = 0;
        for (int e = 0; e < NLANE; e++) if (act[e]) nexp++;
        if (ecode != 2'd0) nexp = 0;

        chk(last_code == ecode && (n_fault == (ecode != 0 ? 1 : 0)),
            (ecode == 2'd1) ? "R1" : "R7", $sformatf("tv%0d fault code", t),
            64'(last_code), 64'(ecode));
        chk(n_done == (ecode == 0 ? 1 : 0) && (n_done + n_fault) == 1, "R11",
            $sformatf("tv%0d end pulses", t), 64'(n_done), 64'(ecode == 0 ? 1 : 0));
        chk(n_wr == nexp, "R5", $sformatf("tv%0d write count", t),
            64'(n_wr), 64'(nexp));
        if (ecode == 2'd0 && n_wr == nexp) begin
            k = 0;
            for (int e = 0; e < NLANE; e++) begin
                if (act[e]) begin
                    chk(mon_addr[k] == first + 64'(8 * e), "R2",
                        $sformatf("tv%0d lane %0d addr", t, e),
                        mon_addr[k], first + 64'(8 * e));
                    chk(mon_data[k] == lane_val(t, e), "R4",
                        $sformatf("tv%0d lane %0d data", t, e),
                        mon_data[k], lane_val(t, e));
                    chk(mon_tag[k] == !use_sp, "R6",
                        $sformatf("tv%0d lane %0d tag", t, e),
                        64'(mon_tag[k]), 64'(!use_sp));
                    chk(mon_nt[k] == 1'b1, "R9",
                        $sformatf("tv%0d lane %0d hint", t, e),
                        64'(mon_nt[k]), 64'd1);
                    k++;
                end
            end
        end
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; insn = '0; vreg = '0; pred = '0;
        xbase = '0; sp_val = '0;
        n_wr = 0; n_done = 0; n_fault = 0; last_code = 2'd0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(!busy && !wr_valid && !done && !fault, "R12", "reset outputs",
            {busy, wr_valid, done, fault}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !wr_valid, "R12", "idle after reset",
            {busy, wr_valid}, 64'h0);

        // table: R1 R2 R3 R4 R5 R6 R7 R8 walked in one loop
        for (int t = 0; t < NTV; t++) run_op(t, 1'b0);

        // R11: a second start with an illegal word while busy is ignored
        run_op(0, 1'b1);
        // R3 ignored predicate bits: vector 5 has only non-lead bits set, no write
        run_op(5, 1'b0);
        // R8 empty predicate on misaligned stack pointer faults when the check is on
        run_op(4, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule